// File: doc/BRIEF.md
# Per-Bit Attribute Register Array

This block is a small bank of control and status registers in which every bit has its own access behaviour. The behaviour is fixed at elaboration by a parameter vector that gives each bit a 4-bit attribute code. A simple host port carries an address, write data, a write strobe and a read strobe. Read data is combinational from the current register contents.

Each bit has two hardware inputs. One is a level condition, used by read-only, latch-high and latch-low bits. The other is a set pulse, used by the clear-on-write and clear-on-read status bits. The whole array is also presented on a flat output, so surrounding logic can use the control bits. This includes write-only bits, which the host port cannot read back.

There are two resets. An asynchronous hardware reset loads the reset-value parameter into every bit. A synchronous software reset does the same, except for bits marked in a keep mask. Those bits go on behaving normally.

Top module: `regbit_array`

## Requirements
- R1: Bit i belongs to register i / REG_W at position i % REG_W, and its attribute is BIT_ATTR[4i+3:4i], with these codes: 0 read/write, 1 read-only, 2 write-only, 3 write-1-to-clear, 4 write-any-to-clear, 5 read-to-clear, 6 latch-high, 7 latch-low, 8 self-clearing, 9 self-setting, 10 reserved. `rdata` shows the addressed register in the same cycle, with the value held before any effect of that read.
- R2: A read/write bit takes the write data bit on a write to its register and reads back that value.
- R3: A read-only bit follows `hw_cond` one cycle later, and host writes do not change it.
- R4: A write-only bit stores the write data bit (visible on `bits_o`) and always reads as 0.
- R5: A write-1-to-clear bit is set by `hw_set`. A write of 1 clears it, and a write of 0 keeps it. A same-cycle `hw_set` wins over the clear.
- R6: A write-any-to-clear bit is set by `hw_set` and cleared by any write to its register, whatever the data. Reads and writes to other registers leave it alone.
- R7: A read-to-clear bit is set by `hw_set` and cleared at the edge that ends a read of its register. Writes do not affect it, and a same-cycle `hw_set` wins over the read.
- R8: A latch-high bit becomes 1 while `hw_cond` is 1 and holds 1 until its register is read. After the read it is 0 if `hw_cond` is low and 1 if `hw_cond` is still high.
- R9: A latch-low bit becomes 0 while `hw_cond` is 0 and holds 0 until its register is read. After the read it is 1 only if `hw_cond` is high.
- R10: A self-clearing bit is set by a write of 1 and returns to 0 one cycle later. A write of 0 has no effect.
- R11: A self-setting bit is cleared by a write of 0 and returns to 1 one cycle later. A write of 1 has no effect.
- R12: A reserved bit ignores writes, reads as 0 and is 0 on `bits_o`.
- R13: While `sw_rst` is high, every bit outside KEEP_ON_SWRST takes its RST_VAL value at the next edge, overriding a write in the same cycle. Bits in the mask keep their normal behaviour.
- R14: While `rst_n` is low, every bit holds its RST_VAL value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| addr | input | ADDR_W | Register index for reads and writes |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | REG_W | Write data |
| rd_en | input | 1 | Read strobe; clear-on-read effects apply at the closing edge |
| rdata | output | REG_W | Read view of the addressed register |
| hw_cond | input | NUM_REGS*REG_W | Per-bit level condition |
| hw_set | input | NUM_REGS*REG_W | Per-bit set event |
| bits_o | output | NUM_REGS*REG_W | Present contents of every bit |

## Verification
If a bit's stored state is wrong, it shows on `bits_o` at the very next edge. It also shows on `rdata` in the first read of its register. The latch and clear-on-read bits need the most care. A missed capture or a wrong release only becomes visible after a read, so the bench reads each of them twice around a condition change and checks `bits_o` between the reads. Self-clearing and self-setting bits are checked in the cycle right after the write, because a stuck value there lasts only one cycle longer than normal.

// File: rtl/regbit_pkg.sv
package regbit_pkg;

    typedef enum logic [3:0] {
        BA_RW   = 4'd0,
        BA_RO   = 4'd1,
        BA_WO   = 4'd2,
        BA_W1C  = 4'd3,
        BA_WAC  = 4'd4,
        BA_RC   = 4'd5,
        BA_LH   = 4'd6,
        BA_LL   = 4'd7,
        BA_SC   = 4'd8,
        BA_SS   = 4'd9,
        BA_RSV  = 4'd10
    } bit_attr_e;

endpackage

// File: rtl/regbit_decode.sv
module regbit_decode #(
    parameter int NUM_REGS = 2,
    parameter int ADDR_W   = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign wr_hit[r] = wr_en && (addr == ADDR_W'(r));
        assign rd_hit[r] = rd_en && (addr == ADDR_W'(r));
    end

endmodule

// File: rtl/regbit_cell.sv
module regbit_cell
    import regbit_pkg::*;
#(
    parameter logic [3:0] ATTR = 4'd0
) (
    input  logic q,
    input  logic wr_hit,
    input  logic rd_hit,
    input  logic wbit,
    input  logic cond,
    input  logic set,
    output logic nxt,
    output logic view
);

    always_comb begin
        nxt  = q;
        view = q;
        case (bit_attr_e'(ATTR))
            BA_RW:  nxt = wr_hit ? wbit : q;
            BA_RO:  nxt = cond;
            BA_WO: begin
                nxt  = wr_hit ? wbit : q;
                view = 1'b0;
            end
            BA_W1C: nxt = set | (q & ~(wr_hit & wbit));
            BA_WAC: nxt = set | (q & ~wr_hit);
            BA_RC:  nxt = set | (q & ~rd_hit);
            BA_LH:  nxt = cond | (q & ~rd_hit);
            BA_LL:  nxt = cond & (q | rd_hit);
            BA_SC:  nxt = wr_hit & wbit;
            BA_SS:  nxt = ~(wr_hit & ~wbit);
            default: begin
                nxt  = 1'b0;
                view = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/regbit_rdmux.sv
module regbit_rdmux #(
    parameter int NUM_REGS = 2,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 1,
    localparam int NBITS   = NUM_REGS * REG_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBITS-1:0]  view,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(r)) begin
                rdata = view[r*REG_W +: REG_W];
            end
        end
    end

endmodule

// File: rtl/regbit_array.sv
module regbit_array #(
    parameter int NUM_REGS = 2,
    parameter int REG_W    = 8,
    parameter logic [NUM_REGS*REG_W*4-1:0] BIT_ATTR      = '0,
    parameter logic [NUM_REGS*REG_W-1:0]   RST_VAL       = '0,
    parameter logic [NUM_REGS*REG_W-1:0]   KEEP_ON_SWRST = '0,
    localparam int NBITS  = NUM_REGS * REG_W,
    localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    input  logic [NBITS-1:0]  hw_cond,
    input  logic [NBITS-1:0]  hw_set,
    output logic [NBITS-1:0]  bits_o
);

    typedef struct packed {
        logic [NBITS-1:0] bits;
    } array_state_t;

    array_state_t st_d, st_q;

    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;
    logic [NBITS-1:0]    func_nxt;
    logic [NBITS-1:0]    rd_view;

    regbit_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam int         RI = i / REG_W;
        localparam int         BI = i % REG_W;
        localparam logic [3:0] A  = BIT_ATTR[4*i +: 4];

        regbit_cell #(
            .ATTR (A)
        ) u_cell (
            .q      (st_q.bits[i]),
            .wr_hit (wr_hit[RI]),
            .rd_hit (rd_hit[RI]),
            .wbit   (wdata[BI]),
            .cond   (hw_cond[i]),
            .set    (hw_set[i]),
            .nxt    (func_nxt[i]),
            .view   (rd_view[i])
        );
    end

    regbit_rdmux #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) u_rdmux (
        .addr  (addr),
        .view  (rd_view),
        .rdata (rdata)
    );

    always_comb begin
        st_d = st_q;
        if (sw_rst) begin
            st_d.bits = (func_nxt & KEEP_ON_SWRST) | (RST_VAL & ~KEEP_ON_SWRST);
        end else begin
            st_d.bits = func_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;

endmodule

// File: rtl/regbit_array_chk.sv
module regbit_array_chk
    import regbit_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int REG_W    = 8,
    parameter logic [NUM_REGS*REG_W*4-1:0] BIT_ATTR      = '0,
    parameter logic [NUM_REGS*REG_W-1:0]   RST_VAL       = '0,
    parameter logic [NUM_REGS*REG_W-1:0]   KEEP_ON_SWRST = '0,
    localparam int NBITS  = NUM_REGS * REG_W,
    localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [REG_W-1:0]  wdata,
    input logic              rd_en,
    input logic [REG_W-1:0]  rdata,
    input logic [NBITS-1:0]  hw_cond,
    input logic [NBITS-1:0]  hw_set,
    input logic [NBITS-1:0]  bits_o
);

    logic unused_inputs;
    assign unused_inputs = ^{wdata, rdata, hw_cond, hw_set, addr, wr_en, rd_en};

    // R13: non-kept bits land on their reset values after a software reset
    assert_swrst_values_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (((bits_o ^ RST_VAL) & ~KEEP_ON_SWRST) == '0));

    for (genvar i = 0; i < NBITS; i++) begin : g_chk
        localparam int         RI = i / REG_W;
        localparam int         BI = i % REG_W;
        localparam logic [3:0] A  = BIT_ATTR[4*i +: 4];

        if (A == 4'(BA_RW)) begin : g_rw
            assert_rw_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_W'(RI) && !sw_rst) |=> (bits_o[i] == $past(wdata[BI])));
        end
        if (A == 4'(BA_RO)) begin : g_ro
            assert_ro_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !sw_rst |=> (bits_o[i] == $past(hw_cond[i])));
        end
        if (A == 4'(BA_WO) || A == 4'(BA_RSV)) begin : g_hide
            assert_hidden_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && addr == ADDR_W'(RI)) |-> !rdata[BI]);
        end
        if (A == 4'(BA_W1C) || A == 4'(BA_WAC) || A == 4'(BA_RC)) begin : g_evt
            assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_set[i] && !sw_rst) |=> bits_o[i]);
        end
        if (A == 4'(BA_LH)) begin : g_lh
            assert_lh_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_cond[i] && !sw_rst) |=> bits_o[i]);
        end
        if (A == 4'(BA_LL)) begin : g_ll
            assert_ll_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!hw_cond[i] && !sw_rst) |=> !bits_o[i]);
        end
        if (A == 4'(BA_SC)) begin : g_sc
            assert_sc_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (bits_o[i] && !(wr_en && addr == ADDR_W'(RI) && wdata[BI]) && !sw_rst)
                |=> !bits_o[i]);
        end
        if (A == 4'(BA_SS)) begin : g_ss
            assert_ss_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (!bits_o[i] && !(wr_en && addr == ADDR_W'(RI) && !wdata[BI]) && !sw_rst)
                |=> bits_o[i]);
        end
        if (A == 4'(BA_RSV)) begin : g_rsv
            assert_rsv_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
                !bits_o[i]);
        end
    end

endmodule

bind regbit_array regbit_array_chk #(
    .NUM_REGS      (NUM_REGS),
    .REG_W         (REG_W),
    .BIT_ATTR      (BIT_ATTR),
    .RST_VAL       (RST_VAL),
    .KEEP_ON_SWRST (KEEP_ON_SWRST)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_rst  (sw_rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .hw_cond (hw_cond),
    .hw_set  (hw_set),
    .bits_o  (bits_o)
);

// File: tb/regbit_array_test.sv
module regbit_array_test;

    localparam logic [63:0] ATTRS = 64'hAAA0_0A98_7654_3210;
    localparam logic [15:0] RSTV  = 16'h0A80;
    localparam logic [15:0] KEEP  = 16'h0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [0:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] hw_cond = 16'h0080;
    logic [15:0] hw_set = '0;
    logic [15:0] bits_o;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    regbit_array #(
        .NUM_REGS      (2),
        .REG_W         (8),
        .BIT_ATTR      (ATTRS),
        .RST_VAL       (RSTV),
        .KEEP_ON_SWRST (KEEP)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .hw_cond (hw_cond),
        .hw_set  (hw_set),
        .bits_o  (bits_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard in mid-cycle
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected read", 16'(rdata), 16'hxxxx);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 16'(rdata), 16'(e));
            end
        end
    end

    // all tasks start and end just after a rising edge
    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string t);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failed++;
            total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R14 reset value", bits_o, RSTV);
        rst_n = 1'b1;
        idle(2);

        // R1 read view of both registers
        rd(1'b0, 8'h80, "R1 reg0 after reset");
        rd(1'b1, 8'h0A, "R1 reg1 after reset");

        // R2 / R4
        wr(1'b0, 8'hFF);
        chk("R4 write-only stored", 16'(bits_o[7:0]), 16'h0085);
        rd(1'b0, 8'h81, "R2 R4 readback hides write-only");
        wr(1'b0, 8'h00);
        chk("R2 read/write cleared", 16'(bits_o[7:0]), 16'h0080);

        // R3 read-only
        hw_cond[1] = 1'b1;
        wr(1'b0, 8'h00);
        chk("R3 ro follows cond", 16'(bits_o[1]), 16'h1);
        rd(1'b0, 8'h82, "R3 ro read");
        hw_cond[1] = 1'b0;
        idle(1);
        wr(1'b0, 8'h02);
        chk("R3 ro write ignored", 16'(bits_o[1]), 16'h0);

        // R5 write-1-to-clear
        hw_set[3] = 1'b1; idle(1); hw_set[3] = 1'b0;
        wr(1'b0, 8'h00);
        chk("R5 w1c zero keeps", 16'(bits_o[3]), 16'h1);
        wr(1'b0, 8'h08);
        chk("R5 w1c one clears", 16'(bits_o[3]), 16'h0);
        hw_set[3] = 1'b1; wr(1'b0, 8'h08); hw_set[3] = 1'b0;
        chk("R5 w1c event wins", 16'(bits_o[3]), 16'h1);
        wr(1'b0, 8'h08);

        // R6 write-any-to-clear
        hw_set[4] = 1'b1; idle(1); hw_set[4] = 1'b0;
        rd(1'b0, 8'h90, "R6 wac read");
        chk("R6 wac read keeps", 16'(bits_o[4]), 16'h1);
        wr(1'b1, 8'h0A);
        chk("R6 wac other reg keeps", 16'(bits_o[4]), 16'h1);
        wr(1'b0, 8'h00);
        chk("R6 wac any write clears", 16'(bits_o[4]), 16'h0);

        // R7 read-to-clear
        hw_set[5] = 1'b1; idle(1); hw_set[5] = 1'b0;
        wr(1'b0, 8'h00);
        chk("R7 rc write ignored", 16'(bits_o[5]), 16'h1);
        rd(1'b0, 8'hA0, "R7 rc read old value");
        chk("R7 rc cleared by read", 16'(bits_o[5]), 16'h0);
        hw_set[5] = 1'b1; rd(1'b0, 8'h80, "R7 rc read with event"); hw_set[5] = 1'b0;
        chk("R7 rc event wins", 16'(bits_o[5]), 16'h1);
        rd(1'b0, 8'hA0, "R7 rc second read");

        // R8 latch-high
        hw_cond[6] = 1'b1; idle(1); hw_cond[6] = 1'b0; idle(2);
        chk("R8 lh held", 16'(bits_o[6]), 16'h1);
        rd(1'b0, 8'hC0, "R8 lh read");
        chk("R8 lh released", 16'(bits_o[6]), 16'h0);
        hw_cond[6] = 1'b1; idle(1);
        rd(1'b0, 8'hC0, "R8 lh read cond high");
        chk("R8 lh stays while high", 16'(bits_o[6]), 16'h1);
        hw_cond[6] = 1'b0;
        rd(1'b0, 8'hC0, "R8 lh read cond dropped");
        chk("R8 lh clears after drop", 16'(bits_o[6]), 16'h0);

        // R9 latch-low
        hw_cond[7] = 1'b0; idle(1); hw_cond[7] = 1'b1; idle(1);
        chk("R9 ll held low", 16'(bits_o[7]), 16'h0);
        rd(1'b0, 8'h00, "R9 ll read");
        chk("R9 ll released", 16'(bits_o[7]), 16'h1);
        hw_cond[7] = 1'b0;
        rd(1'b0, 8'h80, "R9 ll read cond low");
        chk("R9 ll stays low", 16'(bits_o[7]), 16'h0);
        hw_cond[7] = 1'b1; idle(1);
        chk("R9 ll waits for read", 16'(bits_o[7]), 16'h0);
        rd(1'b0, 8'h00, "R9 ll final read");
        chk("R9 ll final release", 16'(bits_o[7]), 16'h1);

        // R10 self-clearing
        wr(1'b1, 8'h0B);
        chk("R10 sc set", 16'(bits_o[8]), 16'h1);
        idle(1);
        chk("R10 sc returns", 16'(bits_o[8]), 16'h0);

        // R11 self-setting
        wr(1'b1, 8'h08);
        chk("R11 ss cleared", 16'(bits_o[9]), 16'h0);
        idle(1);
        chk("R11 ss returns", 16'(bits_o[9]), 16'h1);

        // R12 reserved
        wr(1'b1, 8'hFF);
        chk("R12 rsv ignore write", 16'(bits_o[15:8]), 16'h001B);
        rd(1'b1, 8'h1B, "R12 rsv read zero");
        chk("R12 after read", 16'(bits_o[15:8]), 16'h001A);

        // R13 software reset
        wr(1'b1, 8'h12);
        wr(1'b0, 8'h01);
        sw_rst = 1'b1; idle(1); sw_rst = 1'b0;
        chk("R13 swrst keeps immune zero", bits_o, 16'h0280);
        wr(1'b1, 8'h0A);
        sw_rst = 1'b1; wr(1'b0, 8'h01); sw_rst = 1'b0;
        chk("R13 swrst beats write", bits_o, 16'h0A80);

        // R14 asynchronous reset
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h02);
        chk("R14 pre-reset state", bits_o, 16'h0281);
        rst_n = 1'b0;
        #1;
        chk("R14 async reset", bits_o, RSTV);
        idle(1);
        rst_n = 1'b1;
        idle(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule